// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the low `WIDTH` bits of the product. It can optionally add a third operand, which turns the operation into a multiply-accumulate. Each cycle it takes one overlapping three-bit slice of the multiplier and turns it into a signed digit in the range -2 to +2. It adds that many copies of the multiplicand into a running sum, then moves on by two bit positions. A full operation therefore takes `WIDTH/2` cycles.

A client samples `busy_o` low and raises `start_i` for one cycle, with both operands, the accumulate enable and the addend valid in that cycle. The block then raises `busy_o`, iterates, and signals completion with a single-cycle `done_o`. The result stays on `result_o` until the next accepted start. Parameter `ACC_EN` selects whether the accumulate path is built at all.

Top module: `booth_mul_iter`

## Requirements
- R1: Each digit comes from the slice (m[2i+1], m[2i], m[2i-1]) of the multiplier, with m[-1] taken as 0. The slices map as follows: 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, 101 and 110 give -1. After the first iteration of a multiply, `result_o` equals that first digit times the multiplicand, modulo 2^WIDTH.
- R2: A start is accepted when `start_i` is high and `busy_o` is low at a rising edge. `busy_o` is then high for exactly WIDTH/2 cycles.
- R3: With accumulation off, the final result is the signed product of the two operands truncated to WIDTH bits. For example, 6 times -6 at WIDTH=32 gives 0xFFFFFFDC, and at WIDTH=4 gives 0xC.
- R4: With `ACC_EN`=1 and `acc_en_i` high at start, the result is the product plus `addend_i`, modulo 2^WIDTH.
- R5: `done_o` is high for exactly one cycle, in the cycle right after the last iteration. `busy_o` is low in that cycle.
- R6: `start_i` while `busy_o` is high has no effect. The operands presented with it are not captured, and the result is that of the operation in progress.
- R7: After `done_o`, `result_o` holds its value while no start is accepted, even if the operand inputs change.
- R8: After reset, `busy_o`, `done_o` and `result_o` are all zero.
- R9: A start presented in the cycle where `done_o` is high is accepted, so operations can run back to back.
- R10: With `ACC_EN`=0, `acc_en_i` and `addend_i` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| mcand_i | input | WIDTH | Multiplicand, signed |
| mplier_i | input | WIDTH | Multiplier, signed |
| acc_en_i | input | 1 | Add `addend_i` into the result |
| addend_i | input | WIDTH | Accumulate operand |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Low WIDTH bits of the result |

## Verification
The two functions that can meet in one cycle are the completion pulse of one operation and the acceptance of the next start. The bench provokes this throughout the exhaustive 6-bit sweep. It raises the next start in the very cycle it sees `done_o`, then judges that the new operation reports the full busy length and its own correct product. The opposite overlap, a start arriving mid-iteration, is provoked on the 32-bit instance with different operands. It is judged by the first operation's result being unchanged.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
   // one recoded radix-4 digit: magnitude select plus sign
   typedef struct packed {
      logic neg;   // subtract the selected multiple
      logic one;   // magnitude 1
      logic two;   // magnitude 2
   } bdigit_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_mul_pkg::*;
(
   input  logic [2:0] win_i,   // {upper, middle, lower} bit of the slice
   output bdigit_t    dig_o
);
   always_comb begin
      dig_o = '0;
      unique case (win_i)
         3'b001, 3'b010: dig_o = '{neg: 1'b0, one: 1'b1, two: 1'b0};
         3'b011:         dig_o = '{neg: 1'b0, one: 1'b0, two: 1'b1};
         3'b100:         dig_o = '{neg: 1'b1, one: 1'b0, two: 1'b1};
         3'b101, 3'b110: dig_o = '{neg: 1'b1, one: 1'b1, two: 1'b0};
         default:        dig_o = '0;
      endcase
   end

   // R1: a digit never selects both magnitudes at once
   always_comb a_r1_mag_onehot: assert ($onehot0({dig_o.one, dig_o.two}));
endmodule

// File: rtl/booth_pp_step.sv
module booth_pp_step
   import booth_mul_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] acc_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  bdigit_t          dig_i,
   output logic [WIDTH-1:0] acc_o
);
   logic [WIDTH-1:0] mult;
   logic [WIDTH-1:0] term;

   always_comb begin
      if (dig_i.two)      mult = mcand_i << 1;
      else if (dig_i.one) mult = mcand_i;
      else                mult = '0;
      // negative multiples: invert, and the +1 enters as carry-in
      term  = dig_i.neg ? ~mult : mult;
      acc_o = acc_i + term + WIDTH'(dig_i.neg);
   end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
   parameter int STEPS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic load_o,
   output logic busy_o,
   output logic done_o
);
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q, done_q;

   assign load_o = start_i & ~busy_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= busy_q && (cnt_q == LAST);
         if (load_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == LAST) busy_q <= 1'b0;
            else               cnt_q  <= cnt_q + 1'b1;
         end
      end
   end

   // R5: completion is a single-cycle pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R5: completion follows an iterating cycle and does not overlap it
   a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && $past(busy_q)));
   // R2: busy only begins from an accepted request
   a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start_i));
   // R2: iteration counter stays inside the step range
   a_r2_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < STEPS);
endmodule

// File: rtl/booth_mul_iter.sv
module booth_mul_iter
   import booth_mul_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit ACC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [WIDTH-1:0] mcand_i,
   input  logic [WIDTH-1:0] mplier_i,
   input  logic             acc_en_i,
   input  logic [WIDTH-1:0] addend_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] result_o
);
   localparam int STEPS = WIDTH / 2;

   generate
      if (WIDTH < 4 || (WIDTH % 2) != 0) begin : g_bad_width
         $error("booth_mul_iter: WIDTH must be even and at least 4");
      end
   endgenerate

   logic             load;
   logic [WIDTH-1:0] acc_q, mcand_q, mplr_q;
   logic             prev_q;
   logic [WIDTH-1:0] acc_nxt, acc_init;
   bdigit_t          dig;

   generate
      if (ACC_EN) begin : g_acc
         assign acc_init = acc_en_i ? addend_i : '0;
      end else begin : g_noacc
         assign acc_init = '0;
      end
   endgenerate

   booth_seq_ctrl #(.STEPS(STEPS)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .load_o  (load),
      .busy_o  (busy_o),
      .done_o  (done_o)
   );

   booth_recode recode_i (
      .win_i (({mplr_q[1:0], prev_q})),
      .dig_o (dig)
   );

   booth_pp_step #(.WIDTH(WIDTH)) step_i (
      .acc_i   (acc_q),
      .mcand_i (mcand_q),
      .dig_i   (dig),
      .acc_o   (acc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         mcand_q <= '0;
         mplr_q  <= '0;
         prev_q  <= 1'b0;
      end else if (load) begin
         acc_q   <= acc_init;
         mcand_q <= mcand_i;
         mplr_q  <= mplier_i;
         prev_q  <= 1'b0;        // implicit zero below the lowest bit
      end else if (busy_o) begin
         acc_q   <= acc_nxt;
         mcand_q <= mcand_q << 2;  // next digit weighs four times more
         mplr_q  <= mplr_q >> 2;
         prev_q  <= mplr_q[1];
      end
   end

   assign result_o = acc_q;

   // R7: result is frozen while idle with no accepted start
   a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(result_o));
   // R6: a request during iteration does not restart the sequence
   a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/booth_mul_iter_tb_top.sv
module booth_mul_iter_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int n_chk = 0;
   int n_err = 0;

   // index 0: WIDTH=32 with accumulate, 1: WIDTH=6 with accumulate,
   // 2: WIDTH=4 without accumulate
   logic [31:0] a_b [3];
   logic [31:0] b_b [3];
   logic [31:0] ad_b[3];
   logic        st  [3];
   logic        en  [3];
   logic        busy_w[3];
   logic        done_w[3];
   logic [31:0] res_w [3];

   assign res_w[1][31:6] = '0;
   assign res_w[2][31:4] = '0;

   booth_mul_iter #(.WIDTH(32), .ACC_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(st[0]), .mcand_i(a_b[0]),
      .mplier_i(b_b[0]), .acc_en_i(en[0]), .addend_i(ad_b[0]),
      .busy_o(busy_w[0]), .done_o(done_w[0]), .result_o(res_w[0]));

   booth_mul_iter #(.WIDTH(6), .ACC_EN(1'b1)) dut6_i (
      .clk(clk), .rst_n(rst_n), .start_i(st[1]), .mcand_i(a_b[1][5:0]),
      .mplier_i(b_b[1][5:0]), .acc_en_i(en[1]), .addend_i(ad_b[1][5:0]),
      .busy_o(busy_w[1]), .done_o(done_w[1]), .result_o(res_w[1][5:0]));

   booth_mul_iter #(.WIDTH(4), .ACC_EN(1'b0)) dut4_i (
      .clk(clk), .rst_n(rst_n), .start_i(st[2]), .mcand_i(a_b[2][3:0]),
      .mplier_i(b_b[2][3:0]), .acc_en_i(en[2]), .addend_i(ad_b[2][3:0]),
      .busy_o(busy_w[2]), .done_o(done_w[2]), .result_o(res_w[2][3:0]));

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] sext(input logic [31:0] v, input int w);
      logic signed [31:0] t;
      t = $signed(v << (32 - w));
      return 32'(t >>> (32 - w));
   endfunction

   function automatic logic [31:0] mask(input int w);
      return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
   endfunction

   // starts at a falling edge, returns at the falling edge showing done
   task automatic run_op(input int k, input int w, input bit acc_built,
                         input logic [31:0] a, input logic [31:0] b,
                         input bit e, input logic [31:0] ad,
                         input bit intrude, input bit chk_first);
      longint      prod;
      logic [31:0] exp, first;
      int          cyc;
      prod = longint'($signed(sext(a, w))) * longint'($signed(sext(b, w)));
      exp  = (32'(prod) + ((e && acc_built) ? ad : 32'h0)) & mask(w);
      // R1: first digit from (b1, b0, implicit 0) = b0 - 2*b1
      first = 32'((e && acc_built) ? ad : 32'h0)
            + 32'(a * (int'(b[0]) - 2 * int'(b[1])));
      first = first & mask(w);
      a_b[k] = a; b_b[k] = b; en[k] = e; ad_b[k] = ad; st[k] = 1'b1;
      @(negedge clk);
      st[k] = 1'b0;
      cyc = 0;
      while (!done_w[k] && cyc < 100) begin
         if (busy_w[k]) cyc++;
         if (chk_first && cyc == 2)
            check(res_w[k] == first, "R1 first digit partial", res_w[k], first);
         if (intrude && cyc == 2) begin
            a_b[k] = ~a; b_b[k] = b + 32'd3; st[k] = 1'b1;
         end else begin
            st[k] = 1'b0;
         end
         @(negedge clk);
      end
      st[k] = 1'b0;
      check(cyc == w / 2, "R2 busy length", 32'(cyc), 32'(w / 2));
      check(!busy_w[k], "R5 busy low with done", 32'(busy_w[k]), 32'h0);
      if (intrude)
         check(res_w[k] == exp, "R6 start ignored while busy", res_w[k], exp);
      else if (!acc_built)
         check(res_w[k] == exp, "R10 accumulate absent", res_w[k], exp);
      else if (e)
         check(res_w[k] == exp, "R4 accumulate result", res_w[k], exp);
      else
         check(res_w[k] == exp, "R3 product result", res_w[k], exp);
   endtask

   task automatic hold_check(input int k, input logic [31:0] exp_res);
      a_b[k] = 32'h1234_5678; b_b[k] = 32'h0F0F_0F0F;
      @(negedge clk);
      check(!done_w[k], "R5 done one cycle", 32'(done_w[k]), 32'h0);
      repeat (3) @(negedge clk);
      check(res_w[k] == exp_res, "R7 result held", res_w[k], exp_res);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : stim
      logic [31:0] corners[5];
      logic [31:0] r;
      corners[0] = 32'h0;         corners[1] = 32'hFFFF_FFFF;
      corners[2] = 32'h8000_0000; corners[3] = 32'h7FFF_FFFF;
      corners[4] = 32'h0000_0001;
      for (int k = 0; k < 3; k++) begin
         a_b[k] = '0; b_b[k] = '0; ad_b[k] = '0; st[k] = 1'b0; en[k] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         check(!busy_w[k] && !done_w[k], "R8 reset flags",
               {30'h0, busy_w[k], done_w[k]}, 32'h0);
         check(res_w[k] == 32'h0, "R8 reset result", res_w[k], 32'h0);
      end

      // R3 worked example on both widths
      run_op(0, 32, 1'b1, 32'd6, 32'hFFFF_FFFA, 1'b0, 32'h0, 1'b0, 1'b1);
      check(res_w[0] == 32'hFFFF_FFDC, "R3 example 32-bit", res_w[0], 32'hFFFF_FFDC);
      hold_check(0, 32'hFFFF_FFDC);
      run_op(2, 4, 1'b0, 32'h6, 32'hA, 1'b0, 32'h0, 1'b0, 1'b1);
      check(res_w[2] == 32'hC, "R3 example 4-bit", res_w[2], 32'hC);
      @(negedge clk);

      // corner operands at full width, with and without accumulate
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 5; j++) begin
            run_op(0, 32, 1'b1, corners[i], corners[j], (i + j) % 2 == 1,
                   corners[(i + 2 * j) % 5], 1'b0, 1'b1);
            @(negedge clk);
         end
      // pseudo-random operands, some with an intruding start (R6)
      r = 32'h1357_9BDF;
      for (int i = 0; i < 40; i++) begin
         logic [31:0] x, y, z;
         r = r * 32'd1664525 + 32'd1013904223; x = r;
         r = r * 32'd1664525 + 32'd1013904223; y = r;
         r = r * 32'd1664525 + 32'd1013904223; z = r;
         run_op(0, 32, 1'b1, x, y, i[0], z, i % 4 == 3, 1'b1);
         if (i % 8 == 0) hold_check(0, res_w[0]);
         else @(negedge clk);
      end

      // exhaustive 6-bit sweep, back to back: each start lands on done (R9)
      for (int a = 0; a < 64; a++)
         for (int b = 0; b < 64; b++)
            run_op(1, 6, 1'b1, 32'(a), 32'(b), ((a ^ b) & 1) == 1,
                   32'((a * 7 + b * 3) & 63), 1'b0, 1'b1);
      check(done_w[1], "R9 back-to-back end", 32'(done_w[1]), 32'h1);

      // exhaustive 4-bit sweep on the variant without accumulate (R10)
      for (int a = 0; a < 16; a++)
         for (int b = 0; b < 16; b++)
            run_op(2, 4, 1'b0, 32'(a), 32'(b), 1'b1, 32'(a + b + 1), 1'b0, 1'b1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule